// File: doc/BRIEF.md
# SD Command Path Engine

This block drives the command line of an SD/MMC card. A host launches a command with a pulse that carries a 6-bit index, a 32-bit argument, a 2-bit response-type code and a flag marking the command as part of a data transfer. The engine builds the 48-bit command frame with its CRC7 and shifts it out one bit per clock, MSB first. If a response is expected, it then watches the incoming command line for a start bit. It captures either a 48-bit or a 136-bit response, checks its CRC7, and reports the outcome through sticky status flags.

The flags cover four outcomes: command sent (for commands without a response), response received, CRC failure and timeout. They stay set until the host clears them with a write-one-to-clear strobe. While a command is in flight the engine raises an active flag and refuses new launches. It also marks the command, for the benefit of a neighbouring data path, as a stop-transmission command (index 12) and/or as one tied to a data transfer.

Top module: `sdc_cmd_engine`

## Requirements
- R1: After reset all status flags, the active flag, the stop and transfer markers, the output enable and all four response words are 0, and the command line output is 1.
- R2: On a launch, starting the cycle after the launch edge, the engine drives exactly 48 bits on cmd_o, one per clock and MSB first: 0, 1, index[5:0], argument[31:0], CRC7 (x^7+x^3+1, zero seed) over those first 40 bits, then 1. cmd_oe_o is high for exactly those 48 cycles, and cmd_o is 1 whenever cmd_oe_o is low.
- R3: A launch is accepted only while active_o is 0. A launch pulse while a command is active is ignored and does not alter the running command or its markers.
- R4: Response-type code 0 means no response, codes 1 and 2 mean a 48-bit response, and code 3 means a 136-bit response. For code 0, sent_o is set and active_o drops at the clock edge that ends the last frame bit.
- R5: When a response is expected, cmd_i is sampled on every clock after the frame, and the first 0 is taken as the start bit. If 64 consecutive samples are 1, timeout_o is set and the command ends. A start bit on the 64th sample is still accepted.
- R6: For a 48-bit response, the CRC7 is computed over frame bits 47:8 and compared with bits 7:1. A match sets resp_ok_o, and a mismatch sets crc_fail_o. Word 0 takes bits 39:8, and words 1 to 3 become 0.
- R7: For a 136-bit response, the CRC7 covers frame bits 127:8 and is compared with bits 7:1. Word 0 holds bits 127:96, word 1 holds 95:64, word 2 holds 63:32 and word 3 holds 31:0.
- R8: Each bit of flag_clr_i clears one flag: bit 0 sent_o, bit 1 resp_ok_o, bit 2 crc_fail_o, bit 3 timeout_o. A flag being set in the same cycle as its clear stays set, and flags otherwise hold until cleared.
- R9: stop_o is high while the active command has index 12, and xfer_o is high while the active command was launched with with_data_i set. Both are low when idle.
- R10: Every finished command sets exactly one completion flag. A timeout never also reports a CRC failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one card bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse |
| index_i | input | 6 | Command index |
| arg_i | input | 32 | Command argument |
| rsp_type_i | input | 2 | Response-type code |
| with_data_i | input | 1 | Command belongs to a data transfer |
| flag_clr_i | input | 4 | Write-one-to-clear for the status flags |
| cmd_i | input | 1 | Incoming command line |
| cmd_o | output | 1 | Outgoing command line |
| cmd_oe_o | output | 1 | Command line drive enable |
| active_o | output | 1 | Command in flight |
| sent_o | output | 1 | No-response command sent |
| resp_ok_o | output | 1 | Response received with good CRC |
| crc_fail_o | output | 1 | Response CRC mismatch |
| timeout_o | output | 1 | No response start bit in time |
| stop_o | output | 1 | Active command is a stop-transmission |
| xfer_o | output | 1 | Active command is tied to a data transfer |
| resp_w0_o | output | 32 | Response word 0 (most significant) |
| resp_w1_o | output | 32 | Response word 1 |
| resp_w2_o | output | 32 | Response word 2 |
| resp_w3_o | output | 32 | Response word 3 (least significant) |

## Verification
Two events can land on the same clock edge: a completion flag being set and the host clearing that flag. The bench holds a clear bit high for the whole life of a command, so the set and the clear coincide at the completion edge. It then expects the flag to read 1 after that edge and 0 one cycle later. A second collision is a launch pulse arriving while a command is still shifting out. The bench requires that this pulse leaves the running frame, its markers and the following idle state untouched, and the per-clock reference model judges both cases.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_SHORT = 2'd1,
    RSP_SHALT = 2'd2,
    RSP_LONG  = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SEND, PH_RESP} phase_e;

  localparam int CMD_LEN   = 48;
  localparam int FLAG_SENT = 0;
  localparam int FLAG_RESP = 1;
  localparam int FLAG_CRC  = 2;
  localparam int FLAG_TOUT = 3;

  function automatic logic [6:0] crc7_step(logic [6:0] c, logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], fb} ^ {3'b000, fb, 3'b000};
  endfunction

  function automatic logic [6:0] crc7_hdr(logic [39:0] h);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_step(c, h[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_crc7_ser.sv
module sdc_crc7_ser
  import sdc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= crc7_step(crc_o, bit_i);
  end
endmodule

// File: rtl/sdc_cmd_tx.sv
module sdc_cmd_tx
  import sdc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [5:0]  index_i,
  input  logic [31:0] arg_i,
  output logic        cmd_o,
  output logic        oe_o,
  output logic        done_o
);
  localparam int CNT_W = $clog2(CMD_LEN);

  logic [CMD_LEN-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q;
  logic [39:0]        hdr;

  assign hdr = {2'b01, index_i, arg_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= {hdr, crc7_hdr(hdr), 1'b1};
      cnt_q  <= CNT_W'(CMD_LEN - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      sr_q  <= {sr_q[CMD_LEN-2:0], 1'b1};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) busy_q <= 1'b0;
    end
  end

  assign oe_o   = busy_q;
  assign cmd_o  = busy_q ? sr_q[CMD_LEN-1] : 1'b1;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/sdc_resp_rx.sv
module sdc_resp_rx
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int LONG_LEN    = 136,
  parameter int SHORT_LEN   = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic         long_i,
  input  logic         cmd_i,
  output logic         to_o,
  output logic         fin_o,
  output logic         crc_ok_o,
  output logic [127:0] resp_o
);
  localparam int TCNT_W = $clog2(TIMEOUT_CYC);
  localparam int POS_W  = $clog2(LONG_LEN);
  localparam int BODY_W = 128;
  localparam int CRC_LO = 8;

  typedef enum logic [1:0] {RX_OFF, RX_WAIT, RX_SHIFT} rx_st_e;

  rx_st_e              st_q;
  logic [TCNT_W-1:0]   tcnt_q;
  logic [POS_W-1:0]    pos_q;
  logic                long_q;
  logic [BODY_W-1:0]   sr_q, sr_nx;
  logic [6:0]          crc;
  logic                crc_en;

  assign sr_nx  = {sr_q[BODY_W-2:0], cmd_i};
  assign crc_en = (st_q == RX_SHIFT) && (pos_q >= POS_W'(CRC_LO)) && (pos_q <= POS_W'(BODY_W - 1));

  sdc_crc7_ser u_crc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_q == RX_WAIT),
    .en_i  (crc_en),
    .bit_i (cmd_i),
    .crc_o (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_OFF;
      tcnt_q <= '0;
      pos_q  <= '0;
      long_q <= 1'b0;
      sr_q   <= '0;
      resp_o <= '0;
    end else begin
      case (st_q)
        RX_OFF: if (arm_i) begin
          st_q   <= RX_WAIT;
          tcnt_q <= '0;
          long_q <= long_i;
        end
        RX_WAIT: begin
          if (!cmd_i) begin
            st_q  <= RX_SHIFT;
            pos_q <= long_q ? POS_W'(LONG_LEN - 2) : POS_W'(SHORT_LEN - 2);
          end else if (tcnt_q == TCNT_W'(TIMEOUT_CYC - 1)) begin
            st_q <= RX_OFF;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        RX_SHIFT: begin
          sr_q <= sr_nx;
          if (pos_q == '0) begin
            st_q   <= RX_OFF;
            resp_o <= long_q ? sr_nx : {sr_nx[39:8], 96'b0};
          end else begin
            pos_q <= pos_q - 1'b1;
          end
        end
        default: st_q <= RX_OFF;
      endcase
    end
  end

  assign to_o     = (st_q == RX_WAIT) && cmd_i && (tcnt_q == TCNT_W'(TIMEOUT_CYC - 1));
  assign fin_o    = (st_q == RX_SHIFT) && (pos_q == '0);
  assign crc_ok_o = (crc == sr_nx[7:1]);
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  parameter int STOP_INDEX  = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [5:0]  index_i,
  input  logic [31:0] arg_i,
  input  logic [1:0]  rsp_type_i,
  input  logic        with_data_i,
  input  logic [3:0]  flag_clr_i,
  input  logic        cmd_i,
  output logic        cmd_o,
  output logic        cmd_oe_o,
  output logic        active_o,
  output logic        sent_o,
  output logic        resp_ok_o,
  output logic        crc_fail_o,
  output logic        timeout_o,
  output logic        stop_o,
  output logic        xfer_o,
  output logic [31:0] resp_w0_o,
  output logic [31:0] resp_w1_o,
  output logic [31:0] resp_w2_o,
  output logic [31:0] resp_w3_o
);
  phase_e       ph_q;
  logic         need_q, long_q, stop_q, xfer_q;
  logic [3:0]   flags_q, set_v;
  logic         launch, tx_done, arm;
  logic         rx_to, rx_fin, rx_ok;
  logic [127:0] resp;
  rsp_kind_e    kind;

  assign kind   = rsp_kind_e'(rsp_type_i);
  assign launch = (ph_q == PH_IDLE) && start_i;
  assign arm    = (ph_q == PH_SEND) && tx_done && need_q;

  sdc_cmd_tx u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch),
    .index_i(index_i),
    .arg_i  (arg_i),
    .cmd_o  (cmd_o),
    .oe_o   (cmd_oe_o),
    .done_o (tx_done)
  );

  sdc_resp_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .long_i  (long_q),
    .cmd_i   (cmd_i),
    .to_o    (rx_to),
    .fin_o   (rx_fin),
    .crc_ok_o(rx_ok),
    .resp_o  (resp)
  );

  always_comb begin
    set_v            = '0;
    set_v[FLAG_SENT] = (ph_q == PH_SEND) && tx_done && !need_q;
    set_v[FLAG_TOUT] = (ph_q == PH_RESP) && rx_to;
    set_v[FLAG_RESP] = (ph_q == PH_RESP) && rx_fin && rx_ok;
    set_v[FLAG_CRC]  = (ph_q == PH_RESP) && rx_fin && !rx_ok && !rx_to;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      need_q  <= 1'b0;
      long_q  <= 1'b0;
      stop_q  <= 1'b0;
      xfer_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      flags_q <= (flags_q & ~flag_clr_i) | set_v;
      case (ph_q)
        PH_IDLE: if (launch) begin
          ph_q   <= PH_SEND;
          need_q <= (kind != RSP_NONE);
          long_q <= (kind == RSP_LONG);
          stop_q <= (index_i == 6'(STOP_INDEX));
          xfer_q <= with_data_i;
        end
        PH_SEND: if (tx_done) ph_q <= need_q ? PH_RESP : PH_IDLE;
        PH_RESP: if (rx_to || rx_fin) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign active_o   = (ph_q != PH_IDLE);
  assign stop_o     = active_o && stop_q;
  assign xfer_o     = active_o && xfer_q;
  assign sent_o     = flags_q[FLAG_SENT];
  assign resp_ok_o  = flags_q[FLAG_RESP];
  assign crc_fail_o = flags_q[FLAG_CRC];
  assign timeout_o  = flags_q[FLAG_TOUT];
  assign resp_w0_o  = resp[127:96];
  assign resp_w1_o  = resp[95:64];
  assign resp_w2_o  = resp[63:32];
  assign resp_w3_o  = resp[31:0];
endmodule

// File: rtl/sdc_cmd_engine_chk.sv
module sdc_cmd_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] flag_clr_i,
  input logic       cmd_o,
  input logic       cmd_oe_o,
  input logic       active_o,
  input logic       sent_o,
  input logic       resp_ok_o,
  input logic       crc_fail_o,
  input logic       timeout_o,
  input logic       stop_o,
  input logic       xfer_o
);
  a_r2_oe_within_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> active_o);

  a_r2_line_idles_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_oe_o |-> cmd_o);

  a_r9_markers_in_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o || xfer_o) |-> active_o);

  a_r3_markers_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && $past(active_o)) |-> ($stable(stop_o) && $stable(xfer_o)));

  a_r10_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> (sent_o || resp_ok_o || crc_fail_o || timeout_o));

  a_r10_tout_not_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !$rose(crc_fail_o));

  a_r8_sent_drop_by_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sent_o) |-> $past(flag_clr_i[0]));

  a_r8_tout_drop_by_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> $past(flag_clr_i[3]));
endmodule

bind sdc_cmd_engine sdc_cmd_engine_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flag_clr_i(flag_clr_i),
  .cmd_o     (cmd_o),
  .cmd_oe_o  (cmd_oe_o),
  .active_o  (active_o),
  .sent_o    (sent_o),
  .resp_ok_o (resp_ok_o),
  .crc_fail_o(crc_fail_o),
  .timeout_o (timeout_o),
  .stop_o    (stop_o),
  .xfer_o    (xfer_o)
);

// File: tb/sdc_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module sdc_cmd_engine_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, with_data = 1'b0, cmd_in = 1'b1;
  logic [5:0]  idx = '0;
  logic [31:0] arg = '0;
  logic [1:0]  typ = '0;
  logic [3:0]  clr = '0;
  logic        cmd_o, cmd_oe, active, sent, rok, crcf, tout, stop, xfer;
  logic [31:0] w0, w1, w2, w3;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #2 clk = ~clk;

  sdc_cmd_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .index_i(idx), .arg_i(arg),
    .rsp_type_i(typ), .with_data_i(with_data), .flag_clr_i(clr), .cmd_i(cmd_in),
    .cmd_o(cmd_o), .cmd_oe_o(cmd_oe), .active_o(active), .sent_o(sent),
    .resp_ok_o(rok), .crc_fail_o(crcf), .timeout_o(tout), .stop_o(stop),
    .xfer_o(xfer), .resp_w0_o(w0), .resp_w1_o(w1), .resp_w2_o(w2), .resp_w3_o(w3)
  );

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_crc(logic [135:0] v, int hi);
    logic [6:0] c = '0;
    for (int i = hi; i >= 8; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // behavioural reference model
  int          m_st = 0, m_tc = 0;
  bit          m_q[$];
  bit          m_rq[$];
  bit          m_need, m_long, m_stop, m_xfer;
  logic [3:0]  m_fl = '0, m_set;
  logic [127:0] m_w = '0;
  logic [135:0] m_v;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_fl = '0; m_w = '0; m_q.delete(); m_rq.delete();
      m_stop = 0; m_xfer = 0;
    end else begin
      m_set = '0;
      case (m_st)
        0: if (start) begin
          m_v = '0;
          m_v[47:8] = {2'b01, idx, arg};
          m_v[7:1] = ref_crc(m_v, 47);
          m_v[0] = 1'b1;
          for (int i = 47; i >= 0; i--) m_q.push_back(m_v[i]);
          m_need = (typ != 2'd0); m_long = (typ == 2'd3);
          m_stop = (idx == 6'd12); m_xfer = with_data;
          m_st = 1;
        end
        1: begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (m_need) begin m_st = 2; m_tc = 0; end
            else begin m_set[0] = 1'b1; m_st = 0; end
          end
        end
        2: if (!cmd_in) begin
          m_rq.delete(); m_rq.push_back(1'b0); m_st = 3;
        end else begin
          m_tc++;
          if (m_tc == 64) begin m_set[3] = 1'b1; m_st = 0; end
        end
        default: begin
          int len;
          m_rq.push_back(cmd_in);
          len = m_long ? 136 : 48;
          if (m_rq.size() == len) begin
            m_v = '0;
            for (int i = 0; i < len; i++) m_v[len-1-i] = m_rq[i];
            if (ref_crc(m_v, m_long ? 127 : 47) == m_v[7:1]) m_set[1] = 1'b1;
            else m_set[2] = 1'b1;
            m_w = m_long ? m_v[127:0] : {m_v[39:8], 96'b0};
            m_st = 0;
          end
        end
      endcase
      m_fl = (m_fl & ~clr) | m_set;
    end
    #1;
    if (rst_n) begin
      logic e_oe, e_cmd, e_act;
      e_oe  = (m_st == 1);
      e_cmd = (m_st == 1) ? m_q[0] : 1'b1;
      e_act = (m_st != 0);
      chk({cmd_oe, cmd_o} == {e_oe, e_cmd}, "R2", "line {oe,cmd}", {cmd_oe, cmd_o}, {e_oe, e_cmd});
      chk(active == e_act, "R4", "active_o", active, e_act);
      chk({tout, crcf, rok, sent} == m_fl, "R8", "flags", {tout, crcf, rok, sent}, m_fl);
      chk({stop, xfer} == {e_act & m_stop, e_act & m_xfer}, "R9", "markers",
          {stop, xfer}, {e_act & m_stop, e_act & m_xfer});
      chk({w0, w1, w2, w3} == m_w, "R7", "words", {w0, w1, w2, w3}, m_w);
    end
  end

  // stimulus helpers
  task automatic launch(logic [5:0] i, logic [31:0] a, logic [1:0] t, logic d);
    @(negedge clk);
    start = 1'b1; idx = i; arg = a; typ = t; with_data = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_send_end();
    while (cmd_oe) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (active) @(negedge clk);
  endtask

  task automatic respond(logic [135:0] fr, int len, int delay);
    for (int i = 0; i < delay; i++) begin cmd_in = 1'b1; @(negedge clk); end
    for (int i = len - 1; i >= 0; i--) begin cmd_in = fr[i]; @(negedge clk); end
    cmd_in = 1'b1;
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 4'hF;
    @(negedge clk); clr = 4'h0;
  endtask

  function automatic logic [135:0] short_rsp(logic [5:0] i, logic [31:0] p, bit bad);
    logic [135:0] v = '0;
    v[45:40] = i; v[39:8] = p;
    v[7:1] = ref_crc(v, 47) ^ (bad ? 7'h04 : 7'h00);
    v[0] = 1'b1;
    return v;
  endfunction

  function automatic logic [135:0] long_rsp(logic [119:0] body, bit bad);
    logic [135:0] v = '0;
    v[133:128] = 6'h3F; v[127:8] = body;
    v[7:1] = ref_crc(v, 127) ^ (bad ? 7'h40 : 7'h00);
    v[0] = 1'b1;
    return v;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
    finish_run();
  end

  initial begin
    logic [119:0] body;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sent, rok, crcf, tout, active, stop, xfer, cmd_oe} == 8'h00, "R1", "flags/active",
        {sent, rok, crcf, tout, active, stop, xfer, cmd_oe}, 0);
    chk(cmd_o == 1'b1, "R1", "cmd_o idle", cmd_o, 1);
    chk({w0, w1, w2, w3} == 128'h0, "R1", "words", {w0, w1, w2, w3}, 0);
    rst_n = 1'b1;

    // R4 no-response command
    launch(6'd0, 32'h0, 2'd0, 1'b0);
    wait_send_end();
    chk({sent, rok, crcf, tout, active} == 5'b10000, "R4", "no-resp done",
        {sent, rok, crcf, tout, active}, 5'b10000);
    clear_all();
    @(negedge clk);
    chk({sent, rok, crcf, tout} == 4'h0, "R8", "cleared", {sent, rok, crcf, tout}, 0);

    // R6 short response, good CRC
    launch(6'd17, 32'h1234_5678, 2'd1, 1'b1);
    wait_send_end();
    respond(short_rsp(6'd17, 32'hDEAD_BEEF, 0), 48, 5);
    wait_idle();
    chk(rok && !crcf && !tout, "R6", "short ok flags", {rok, crcf, tout}, 3'b100);
    chk(w0 == 32'hDEAD_BEEF && w1 == 0, "R6", "short word0", w0, 32'hDEAD_BEEF);
    clear_all();

    // R6 short response via code 2, bad CRC
    launch(6'd13, 32'hA5A5_0000, 2'd2, 1'b0);
    wait_send_end();
    respond(short_rsp(6'd13, 32'h0000_0900, 1), 48, 2);
    wait_idle();
    chk(crcf && !rok && !tout, "R6", "short crc fail", {rok, crcf, tout}, 3'b010);
    clear_all();

    // R7 long response, good CRC
    body = 120'h0102_0304_0506_0708_090A_0B0C_0D0E_0F;
    launch(6'd2, 32'h0, 2'd3, 1'b0);
    wait_send_end();
    respond(long_rsp(body, 0), 136, 7);
    wait_idle();
    chk(rok && !crcf, "R7", "long ok", {rok, crcf}, 2'b10);
    chk(w0 == body[119:88], "R7", "long word0", w0, body[119:88]);
    chk(w3[31:8] == body[23:0], "R7", "long word3", w3[31:8], body[23:0]);
    clear_all();

    // R7 long response, bad CRC
    launch(6'd9, 32'h0001_0000, 2'd3, 1'b0);
    wait_send_end();
    respond(long_rsp(~body, 1), 136, 0);
    wait_idle();
    chk(crcf && !rok, "R7", "long crc fail", {rok, crcf}, 2'b01);
    clear_all();

    // R5 / R10 timeout: no start bit at all
    launch(6'd8, 32'h0000_01AA, 2'd1, 1'b0);
    wait_send_end();
    wait_idle();
    chk(tout && !crcf && !rok, "R10", "timeout only", {tout, crcf, rok}, 3'b100);
    clear_all();

    // R5 boundary: start bit on the 64th sample
    launch(6'd8, 32'h0000_01AA, 2'd1, 1'b0);
    wait_send_end();
    respond(short_rsp(6'd8, 32'h0000_01AA, 0), 48, 63);
    wait_idle();
    chk(rok && !tout, "R5", "late start accepted", {rok, tout}, 2'b10);
    clear_all();

    // R9 stop-transmission with data flag
    launch(6'd12, 32'h0, 2'd0, 1'b1);
    repeat (5) @(negedge clk);
    chk(stop && xfer, "R9", "markers mid-cmd", {stop, xfer}, 2'b11);
    wait_idle();
    chk(!stop && !xfer, "R9", "markers idle", {stop, xfer}, 2'b00);
    clear_all();

    // R3 launch while active is ignored
    launch(6'd5, 32'h0, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    launch(6'd12, 32'hFFFF_FFFF, 2'd3, 1'b1);
    chk(!stop && !xfer, "R3", "ignored launch markers", {stop, xfer}, 2'b00);
    wait_idle();
    @(negedge clk);
    chk(!active && sent, "R3", "no second command", {active, sent}, 2'b01);
    clear_all();

    // R8 set and clear in the same cycle
    clr = 4'h1;
    launch(6'd0, 32'h0, 2'd0, 1'b0);
    wait_send_end();
    chk(sent == 1'b1, "R8", "set wins over clear", sent, 1);
    @(negedge clk);
    chk(sent == 1'b0, "R8", "clear next cycle", sent, 0);
    clr = 4'h0;

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule